// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small, non-pipelined 16-bit processor. It sequences every instruction through a fixed series of states. It fetches the instruction word over a ready/valid memory handshake and decodes its 5-bit opcode. When the instruction needs a second word it fetches that too. It then steps the datapath through execution by pulsing select, output-enable and load-enable lines. The register file, operand register, result register, program counter, address register, instruction register, ALU, shifter and memory all live outside the block. They share one 16-bit bus. The sequencer decides which single unit drives that bus in each cycle and which units capture it.

Register-to-register arithmetic goes in two steps. The source register is parked in the operand register. The destination register is then placed on the bus, the ALU and shifter result is latched into the result register, and a final cycle copies it back. One instruction fully completes before the next fetch starts.

States, in order of use: `S_INIT` (clear the PC), `S_FADDR` (PC to address register), `S_FWAIT` (read instruction, wait for ready), `S_DECODE` (advance PC, choose a path), `S_OPND` (source to operand register), `S_EVAL` (second operand through ALU and shifter into the result register), `S_WBACK` (result to destination), `S_XADDR` (PC to address register for the second word), `S_XWAIT` (read second word), `S_MLOAD` (memory to register), `S_MSTORE` (register to memory). Transitions: INIT→FADDR, FADDR→FWAIT, FWAIT→DECODE on ready, DECODE→FADDR / OPND / EVAL / XADDR by instruction kind, OPND→EVAL, EVAL→WBACK, WBACK→FADDR, XADDR→XWAIT, XWAIT→MLOAD / MSTORE / FADDR on ready, MLOAD and MSTORE→FADDR on ready. Every waiting state stays put while ready is low.

Top module: `cpu_sequencer`

## Requirements
- R1: A synchronous active-high `rst` holds the block in `S_INIT`. There `pc_clr` is 1, `vma` is 0 and `rw` is 1. After release the first instruction fetch uses address 0.
- R2: A fetch first drives the PC onto the bus with `addr_ld` set. It then holds `vma`=1 and `rw`=0 for as many cycles as `ready` stays low. `ir_ld` is raised only in the cycle where `ready` is 1.
- R3: The opcode is `instr[15:11]`, the source index is `instr[5:3]` and the destination index is `instr[2:0]`. Opcodes: 00000 no-op, 00001 load-from-memory, 00010 store, 00011 move, 00100 load-immediate, 00101 add, 00110 subtract, 00111 and, 01000 or, 01001 invert, 01010 increment, 01011 shift left, 01100 shift right, 01101 rotate left, 01110 rotate right, 01111 jump, 10000 branch-if-compare.
- R4: For load-immediate, the PC is advanced past the first word and the second word is read from the next address. That word is written into the destination register.
- R5: Add, subtract, and and or copy the source register into the operand register, then place the destination register on the bus. The ALU (`alu_sel` 0001 add, 0010 bus minus operand, 0011 and, 0100 or) result is latched into the result register and copied to the destination register. So dst ← src+dst, dst−src, src&dst or src|dst.
- R6: Move places the source register on the bus. Invert and increment place the destination register on the bus. `alu_sel` is 0000 pass, 0101 invert or 0110 increment. The result goes through the result register into the destination register.
- R7: Shifts place the destination register on the bus with `alu_sel`=0000. `shift_sel` is 001 left, 010 right, 011 rotate left or 100 rotate right, and the result is written back to the destination. In every other cycle `shift_sel` is 000 (pass).
- R8: After a non-branch instruction, the next fetch address is the old PC plus the instruction length (1 or 2 words). At most one of `pc_clr`, `pc_inc`, `pc_ld` is asserted in any cycle.
- R9: A jump loads the PC from its second word. Branch-if-compare loads it when `compout` is 1 at the cycle its second word arrives, and otherwise advances past it.
- R10: Load-from-memory and store first load their second word into the address register. A load then reads memory into the destination register. A store holds `vma`=1, `rw`=1 and the destination register on the bus until `ready`, and writes exactly once.
- R11: An opcode not listed in R3 behaves as a no-op that changes no register and advances the PC by one.
- R12: At most one bus source is active per cycle: `reg_oe`, `out_oe`, `pc_oe`, or a memory read (`vma`=1 with `rw`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Current instruction register contents |
| compout | input | 1 | Comparator result used by branch-if-compare |
| ready | input | 1 | Memory has completed the current access |
| rw | output | 1 | 0 = memory read, 1 = write (idle high) |
| vma | output | 1 | Memory address valid |
| reg_sel | output | 3 | Register file index |
| reg_oe | output | 1 | Selected register drives the bus |
| reg_we | output | 1 | Selected register captures the bus |
| op_we | output | 1 | Operand register captures the bus |
| alu_sel | output | 4 | ALU function code |
| shift_sel | output | 3 | Shifter function code |
| out_we | output | 1 | Result register captures shifter output |
| out_oe | output | 1 | Result register drives the bus |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Advance the program counter by one |
| pc_ld | output | 1 | Load the program counter from the bus |
| pc_oe | output | 1 | Program counter drives the bus |
| addr_ld | output | 1 | Address register captures the bus |
| ir_ld | output | 1 | Instruction register captures the bus |

## Verification
The assertions assume that `instr` is stable outside the cycle after `ir_ld`. They also assume that `ready` is only meaningful while `vma` is high, and that memory raises `ready` within a bounded number of cycles. The bench meets these assumptions with a model memory that raises `ready` after a programmable number of valid cycles and drops it as soon as it is consumed. It also keeps an instruction register model that changes only on `ir_ld`. Wait lengths of zero and several cycles are both driven, so the hold-while-waiting properties see both long and zero-length waits.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD_W = 16;
    localparam int OPC_W  = 5;
    localparam int RIDX_W = 3;
    localparam int ALU_W  = 4;
    localparam int SHF_W  = 3;
    localparam int OPC_LSB = WORD_W - OPC_W;

    typedef enum logic [3:0] {
        S_INIT, S_FADDR, S_FWAIT, S_DECODE, S_OPND, S_EVAL,
        S_WBACK, S_XADDR, S_XWAIT, S_MLOAD, S_MSTORE
    } state_t;

    typedef enum logic [SHF_W-1:0] {
        SH_PASS = 3'd0, SH_LEFT = 3'd1, SH_RIGHT = 3'd2,
        SH_ROTL = 3'd3, SH_ROTR = 3'd4
    } shift_t;

    localparam logic [ALU_W-1:0] ALU_PASS = 4'd0;
    localparam logic [ALU_W-1:0] ALU_ADD  = 4'd1;
    localparam logic [ALU_W-1:0] ALU_SUB  = 4'd2;
    localparam logic [ALU_W-1:0] ALU_AND  = 4'd3;
    localparam logic [ALU_W-1:0] ALU_OR   = 4'd4;
    localparam logic [ALU_W-1:0] ALU_NOT  = 4'd5;
    localparam logic [ALU_W-1:0] ALU_INC  = 4'd6;

    localparam logic [OPC_W-1:0] OP_NOP  = 5'b00000;
    localparam logic [OPC_W-1:0] OP_LD   = 5'b00001;
    localparam logic [OPC_W-1:0] OP_ST   = 5'b00010;
    localparam logic [OPC_W-1:0] OP_MOV  = 5'b00011;
    localparam logic [OPC_W-1:0] OP_LDI  = 5'b00100;
    localparam logic [OPC_W-1:0] OP_ADD  = 5'b00101;
    localparam logic [OPC_W-1:0] OP_SUB  = 5'b00110;
    localparam logic [OPC_W-1:0] OP_AND  = 5'b00111;
    localparam logic [OPC_W-1:0] OP_OR   = 5'b01000;
    localparam logic [OPC_W-1:0] OP_NOT  = 5'b01001;
    localparam logic [OPC_W-1:0] OP_INC  = 5'b01010;
    localparam logic [OPC_W-1:0] OP_SHL  = 5'b01011;
    localparam logic [OPC_W-1:0] OP_SHR  = 5'b01100;
    localparam logic [OPC_W-1:0] OP_ROL  = 5'b01101;
    localparam logic [OPC_W-1:0] OP_ROR  = 5'b01110;
    localparam logic [OPC_W-1:0] OP_JMP  = 5'b01111;
    localparam logic [OPC_W-1:0] OP_BCMP = 5'b10000;

    typedef enum logic [2:0] {
        K_NOP, K_TWO, K_ONE, K_IMM, K_BRANCH, K_LOAD, K_STORE
    } kind_t;

    typedef struct packed {
        kind_t            kind;
        logic [ALU_W-1:0] alu;
        shift_t           shf;
        logic             use_src;
        logic             cond;
    } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    always_comb begin
        dec = '{kind: K_NOP, alu: ALU_PASS, shf: SH_PASS, use_src: 1'b0, cond: 1'b0};
        unique case (opcode)
            OP_LD:   dec.kind = K_LOAD;
            OP_ST:   dec.kind = K_STORE;
            OP_MOV:  begin dec.kind = K_ONE; dec.use_src = 1'b1; end
            OP_LDI:  dec.kind = K_IMM;
            OP_ADD:  begin dec.kind = K_TWO; dec.alu = ALU_ADD; end
            OP_SUB:  begin dec.kind = K_TWO; dec.alu = ALU_SUB; end
            OP_AND:  begin dec.kind = K_TWO; dec.alu = ALU_AND; end
            OP_OR:   begin dec.kind = K_TWO; dec.alu = ALU_OR; end
            OP_NOT:  begin dec.kind = K_ONE; dec.alu = ALU_NOT; end
            OP_INC:  begin dec.kind = K_ONE; dec.alu = ALU_INC; end
            OP_SHL:  begin dec.kind = K_ONE; dec.shf = SH_LEFT; end
            OP_SHR:  begin dec.kind = K_ONE; dec.shf = SH_RIGHT; end
            OP_ROL:  begin dec.kind = K_ONE; dec.shf = SH_ROTL; end
            OP_ROR:  begin dec.kind = K_ONE; dec.shf = SH_ROTR; end
            OP_JMP:  dec.kind = K_BRANCH;
            OP_BCMP: begin dec.kind = K_BRANCH; dec.cond = 1'b1; end
            default: dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/seq_state.sv
module seq_state
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ready,
    input  dec_t   dec,
    output state_t state
);
    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_INIT;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_INIT:   nxt = S_FADDR;
            S_FADDR:  nxt = S_FWAIT;
            S_FWAIT:  if (ready) nxt = S_DECODE;
            S_DECODE: begin
                unique case (dec.kind)
                    K_TWO:   nxt = S_OPND;
                    K_ONE:   nxt = S_EVAL;
                    K_IMM, K_BRANCH, K_LOAD, K_STORE: nxt = S_XADDR;
                    default: nxt = S_FADDR;
                endcase
            end
            S_OPND:   nxt = S_EVAL;
            S_EVAL:   nxt = S_WBACK;
            S_WBACK:  nxt = S_FADDR;
            S_XADDR:  nxt = S_XWAIT;
            S_XWAIT: begin
                if (ready) begin
                    if (dec.kind == K_LOAD)       nxt = S_MLOAD;
                    else if (dec.kind == K_STORE) nxt = S_MSTORE;
                    else                          nxt = S_FADDR;
                end
            end
            S_MLOAD, S_MSTORE: if (ready) nxt = S_FADDR;
            default:  nxt = S_INIT;
        endcase
    end
endmodule

// File: rtl/seq_drive.sv
module seq_drive
    import seq_pkg::*;
(
    input  state_t            state,
    input  dec_t              dec,
    input  logic [RIDX_W-1:0] src_idx,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic              ready,
    input  logic              compout,
    output logic              rw,
    output logic              vma,
    output logic [RIDX_W-1:0] reg_sel,
    output logic              reg_oe,
    output logic              reg_we,
    output logic              op_we,
    output logic [ALU_W-1:0]  alu_sel,
    output logic [SHF_W-1:0]  shift_sel,
    output logic              out_we,
    output logic              out_oe,
    output logic              pc_clr,
    output logic              pc_inc,
    output logic              pc_ld,
    output logic              pc_oe,
    output logic              addr_ld,
    output logic              ir_ld
);
    always_comb begin
        rw = 1'b1; vma = 1'b0; reg_sel = dst_idx;
        reg_oe = 1'b0; reg_we = 1'b0; op_we = 1'b0;
        alu_sel = ALU_PASS; shift_sel = SH_PASS;
        out_we = 1'b0; out_oe = 1'b0;
        pc_clr = 1'b0; pc_inc = 1'b0; pc_ld = 1'b0; pc_oe = 1'b0;
        addr_ld = 1'b0; ir_ld = 1'b0;
        unique case (state)
            S_INIT:   pc_clr = 1'b1;
            S_FADDR, S_XADDR: begin
                pc_oe = 1'b1; addr_ld = 1'b1;
            end
            S_FWAIT: begin
                vma = 1'b1; rw = 1'b0; ir_ld = ready;
            end
            S_DECODE: pc_inc = 1'b1;
            S_OPND: begin
                reg_sel = src_idx; reg_oe = 1'b1; op_we = 1'b1;
            end
            S_EVAL: begin
                reg_sel   = dec.use_src ? src_idx : dst_idx;
                reg_oe    = 1'b1;
                alu_sel   = dec.alu;
                shift_sel = dec.shf;
                out_we    = 1'b1;
            end
            S_WBACK: begin
                out_oe = 1'b1; reg_we = 1'b1;
            end
            S_XWAIT: begin
                vma = 1'b1; rw = 1'b0;
                if (ready) begin
                    unique case (dec.kind)
                        K_IMM: begin reg_we = 1'b1; pc_inc = 1'b1; end
                        K_BRANCH: begin
                            if (dec.cond && !compout) pc_inc = 1'b1;
                            else                      pc_ld  = 1'b1;
                        end
                        K_LOAD, K_STORE: begin addr_ld = 1'b1; pc_inc = 1'b1; end
                        default: ;
                    endcase
                end
            end
            S_MLOAD: begin
                vma = 1'b1; rw = 1'b0; reg_we = ready;
            end
            S_MSTORE: begin
                vma = 1'b1; rw = 1'b1; reg_oe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu_sequencer.sv
module cpu_sequencer
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] instr,
    input  logic              compout,
    input  logic              ready,
    output logic              rw,
    output logic              vma,
    output logic [RIDX_W-1:0] reg_sel,
    output logic              reg_oe,
    output logic              reg_we,
    output logic              op_we,
    output logic [ALU_W-1:0]  alu_sel,
    output logic [SHF_W-1:0]  shift_sel,
    output logic              out_we,
    output logic              out_oe,
    output logic              pc_clr,
    output logic              pc_inc,
    output logic              pc_ld,
    output logic              pc_oe,
    output logic              addr_ld,
    output logic              ir_ld
);
    dec_t   dec;
    state_t state;
    logic   unused_fields;

    assign unused_fields = ^instr[OPC_LSB-1:2*RIDX_W];

    seq_decode u_dec (
        .opcode (instr[WORD_W-1:OPC_LSB]),
        .dec    (dec)
    );

    seq_state u_state (
        .clk   (clk),
        .rst   (rst),
        .ready (ready),
        .dec   (dec),
        .state (state)
    );

    seq_drive u_drive (
        .state     (state),
        .dec       (dec),
        .src_idx   (instr[2*RIDX_W-1:RIDX_W]),
        .dst_idx   (instr[RIDX_W-1:0]),
        .ready     (ready),
        .compout   (compout),
        .rw        (rw),
        .vma       (vma),
        .reg_sel   (reg_sel),
        .reg_oe    (reg_oe),
        .reg_we    (reg_we),
        .op_we     (op_we),
        .alu_sel   (alu_sel),
        .shift_sel (shift_sel),
        .out_we    (out_we),
        .out_oe    (out_oe),
        .pc_clr    (pc_clr),
        .pc_inc    (pc_inc),
        .pc_ld     (pc_ld),
        .pc_oe     (pc_oe),
        .addr_ld   (addr_ld),
        .ir_ld     (ir_ld)
    );
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic rw,
    input logic vma,
    input logic reg_oe,
    input logic reg_we,
    input logic out_oe,
    input logic pc_oe,
    input logic pc_clr,
    input logic pc_inc,
    input logic pc_ld,
    input logic ir_ld
);
    // R12
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_oe, out_oe, pc_oe, vma && !rw}));

    // R8
    pc_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_clr, pc_inc, pc_ld}));

    // R2
    ir_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ir_ld |-> (vma && !rw && ready));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vma && !ready) |=> (vma && $stable(rw)));

    // R10
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vma && rw && !ready) |=> (vma && rw && reg_oe));

    // R9
    branch_ready_chk: assert property (@(posedge clk) disable iff (rst)
        pc_ld |-> (vma && !rw && ready));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pc_clr && !vma && rw));

    // R5
    no_self_copy_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !reg_oe);
endmodule

bind cpu_sequencer seq_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .ready  (ready),
    .rw     (rw),
    .vma    (vma),
    .reg_oe (reg_oe),
    .reg_we (reg_we),
    .out_oe (out_oe),
    .pc_oe  (pc_oe),
    .pc_clr (pc_clr),
    .pc_inc (pc_inc),
    .pc_ld  (pc_ld),
    .ir_ld  (ir_ld)
);

// File: tb/cpu_sequencer_tb.sv
module cpu_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 19;

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] w1;
        logic        comp;
        logic        is_mem;
        logic [7:0]  idx;
        logic [15:0] val;
        logic [15:0] npc;
    } vec_t;

    // Initial registers: r[i] = 16*i + 3, except r7 = 0x8001
    localparam vec_t VEC [NVEC] = '{
        '{16'h2001, 16'h0015, 1'b0, 1'b0, 8'd1, 16'h0015, 16'd2},    // R4 load-immediate r1
        '{16'h182A, 16'h0000, 1'b0, 1'b0, 8'd2, 16'h0053, 16'd1},    // R6 move r5->r2
        '{16'h280B, 16'h0000, 1'b0, 1'b0, 8'd3, 16'h0046, 16'd1},    // R5 add
        '{16'h3014, 16'h0000, 1'b0, 1'b0, 8'd4, 16'h0020, 16'd1},    // R5 subtract
        '{16'h383E, 16'h0000, 1'b0, 1'b0, 8'd6, 16'h0001, 16'd1},    // R5 and
        '{16'h403D, 16'h0000, 1'b0, 1'b0, 8'd5, 16'h8053, 16'd1},    // R5 or
        '{16'h4801, 16'h0000, 1'b0, 1'b0, 8'd1, 16'hFFEC, 16'd1},    // R6 invert
        '{16'h5007, 16'h0000, 1'b0, 1'b0, 8'd7, 16'h8002, 16'd1},    // R6 increment
        '{16'h5807, 16'h0000, 1'b0, 1'b0, 8'd7, 16'h0002, 16'd1},    // R7 shift left
        '{16'h6007, 16'h0000, 1'b0, 1'b0, 8'd7, 16'h4000, 16'd1},    // R7 shift right
        '{16'h6807, 16'h0000, 1'b0, 1'b0, 8'd7, 16'h0003, 16'd1},    // R7 rotate left
        '{16'h7007, 16'h0000, 1'b0, 1'b0, 8'd7, 16'hC000, 16'd1},    // R7 rotate right
        '{16'h0000, 16'h0000, 1'b0, 1'b0, 8'd0, 16'h0003, 16'd1},    // R3 no-op
        '{16'hF800, 16'h0000, 1'b0, 1'b0, 8'd0, 16'h0003, 16'd1},    // R11 unimplemented
        '{16'h7800, 16'h0040, 1'b0, 1'b0, 8'd0, 16'h0003, 16'h0040}, // R9 jump
        '{16'h8000, 16'h0030, 1'b1, 1'b0, 8'd0, 16'h0003, 16'h0030}, // R9 branch taken
        '{16'h8000, 16'h0030, 1'b0, 1'b0, 8'd0, 16'h0003, 16'd2},    // R9 branch not taken
        '{16'h0802, 16'h0020, 1'b0, 1'b0, 8'd2, 16'hBEEF, 16'd2},    // R10 load from memory
        '{16'h1003, 16'h0021, 1'b0, 1'b1, 8'h21, 16'h0033, 16'd2}    // R10 store to memory
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr;
    logic        compout = 1'b0;
    logic        ready;
    logic        rw, vma, reg_oe, reg_we, op_we, out_we, out_oe;
    logic        pc_clr, pc_inc, pc_ld, pc_oe, addr_ld, ir_ld;
    logic [2:0]  reg_sel, shift_sel;
    logic [3:0]  alu_sel;

    logic [15:0] mem [256];
    logic [15:0] regs [8];
    logic [15:0] pc, ar, ir, opr, outr, bus;
    int          latency = 0;
    int          wcnt, fetch_n, vma_cycles, writes, conflicts;
    logic [15:0] last_fetch, first_fetch;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_sequencer u_dut (
        .clk(clk), .rst(rst), .instr(instr), .compout(compout), .ready(ready),
        .rw(rw), .vma(vma), .reg_sel(reg_sel), .reg_oe(reg_oe), .reg_we(reg_we),
        .op_we(op_we), .alu_sel(alu_sel), .shift_sel(shift_sel), .out_we(out_we),
        .out_oe(out_oe), .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_ld(pc_ld),
        .pc_oe(pc_oe), .addr_ld(addr_ld), .ir_ld(ir_ld)
    );

    function automatic logic [15:0] init_reg(input int i);
        return (i == 7) ? 16'h8001 : 16'(16 * i + 3);
    endfunction

    function automatic logic [15:0] alu_f(input logic [3:0] s, input logic [15:0] a, b);
        case (s)
            4'd1: return a + b;
            4'd2: return b - a;
            4'd3: return a & b;
            4'd4: return a | b;
            4'd5: return ~b;
            4'd6: return b + 16'd1;
            default: return b;
        endcase
    endfunction

    function automatic logic [15:0] shf_f(input logic [2:0] s, input logic [15:0] v);
        case (s)
            3'd1: return {v[14:0], 1'b0};
            3'd2: return {1'b0, v[15:1]};
            3'd3: return {v[14:0], v[15]};
            3'd4: return {v[0], v[15:1]};
            default: return v;
        endcase
    endfunction

    assign instr = ir;
    assign ready = vma && (wcnt >= latency);

    always_comb begin
        if (reg_oe)          bus = regs[reg_sel];
        else if (out_oe)     bus = outr;
        else if (pc_oe)      bus = pc;
        else if (vma && !rw) bus = mem[ar[7:0]];
        else                 bus = 16'h0000;
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) regs[i] <= init_reg(i);
            ir <= 16'h0000; wcnt <= 0; fetch_n <= 0;
            vma_cycles <= 0; writes <= 0;
        end else begin
            if (!vma || ready) wcnt <= 0;
            else               wcnt <= wcnt + 1;
            if (vma && fetch_n == 0) vma_cycles <= vma_cycles + 1;
            if (ir_ld) begin
                ir <= bus;
                fetch_n <= fetch_n + 1;
                last_fetch <= ar;
                if (fetch_n == 0) first_fetch <= ar;
            end
            if (addr_ld) ar <= bus;
            if (op_we)   opr <= bus;
            if (out_we)  outr <= shf_f(shift_sel, alu_f(alu_sel, opr, bus));
            if (reg_we)  regs[reg_sel] <= bus;
            if (vma && rw && ready) begin
                mem[ar[7:0]] <= bus;
                writes <= writes + 1;
            end
        end
        if (pc_clr)      pc <= 16'h0000;
        else if (pc_inc) pc <= pc + 16'd1;
        else if (pc_ld)  pc <= bus;
    end

    always @(negedge clk) begin
        if (!rst && $countones({reg_oe, out_oe, pc_oe, vma && !rw}) > 1)
            conflicts <= conflicts + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [15:0] w0, w1, input logic cmp, input int lat);
        rst = 1'b1;
        latency = lat;
        compout = cmp;
        for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
        mem[0] = w0;
        mem[1] = w1;
        mem[8'h20] = 16'hBEEF;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        while (fetch_n < 2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        conflicts = 0;
        // R1: reset state outputs
        repeat (2) @(negedge clk);
        check(pc_clr == 1'b1, "R1 pc_clr in reset", {15'd0, pc_clr}, 16'd1);
        check(vma == 1'b0, "R1 vma in reset", {15'd0, vma}, 16'd0);
        check(rw == 1'b1, "R1 rw in reset", {15'd0, rw}, 16'd1);

        for (int v = 0; v < NVEC; v++) begin
            start(VEC[v].w0, VEC[v].w1, VEC[v].comp, 0);
            if (VEC[v].is_mem)
                check(mem[VEC[v].idx] == VEC[v].val, $sformatf("vec%0d mem", v),
                      mem[VEC[v].idx], VEC[v].val);
            else
                check(regs[VEC[v].idx[2:0]] == VEC[v].val, $sformatf("vec%0d reg", v),
                      regs[VEC[v].idx[2:0]], VEC[v].val);
            check(last_fetch == VEC[v].npc, $sformatf("vec%0d next pc (R8)", v),
                  last_fetch, VEC[v].npc);
            // R1: first fetch at address zero
            check(first_fetch == 16'h0000, $sformatf("R1 vec%0d first fetch", v),
                  first_fetch, 16'h0000);
        end

        // R11: unimplemented opcode leaves every register untouched
        start(16'hC8FF, 16'h0000, 1'b0, 0);
        for (int i = 0; i < 8; i++)
            check(regs[i] == init_reg(i), "R11 register untouched", regs[i], init_reg(i));

        // R2: fetch holds valid through 3 wait cycles, loads on 4th
        start(16'h2004, 16'h1234, 1'b0, 3);
        check(vma_cycles == 4, "R2 fetch wait length", 16'(vma_cycles), 16'd4);
        check(regs[4] == 16'h1234, "R4 load-immediate with waits", regs[4], 16'h1234);
        check(last_fetch == 16'd2, "R8 next pc with waits", last_fetch, 16'd2);

        // R10: slow store writes once with correct data
        start(16'h1007, 16'h0021, 1'b0, 2);
        check(mem[8'h21] == 16'h8001, "R10 slow store data", mem[8'h21], 16'h8001);
        check(writes == 1, "R10 single write", 16'(writes), 16'd1);

        // R12: never more than one bus driver
        check(conflicts == 0, "R12 bus conflicts", 16'(conflicts), 16'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule